// File: doc/BRIEF.md
# Floppy Controller Register and Interrupt Core

This block is the byte-wide register file at the heart of a floppy disk controller. A host reaches sixteen 8-bit registers over a simple strobe bus, with the registers 16 bytes apart. It keeps the control word that steers the rest of the controller. That word has no direct write: one address clears bits and another sets them. It also keeps an interrupt cause register with a matching enable mask, a sticky error register and a down-counting microsecond timer. From these it drives one interrupt line.

Seek, sector-read and transfer logic elsewhere in the controller report into this block through sideband pulses. These pulses mark seek done, sector seen, transfer done, data changed and error events. The same logic loads the current-track and current-sector registers directly. A read of the cause or error register clears what it returns. An event that lands in the same cycle as that read is kept for the next read. A software-reset bit in the setup register holds the control, cause, error and timer state at zero for as long as it is set.

The timer is a small state machine with three states. TM_IDLE parks at zero. TM_COUNT decrements once per microsecond tick. TM_DONE is a one-cycle state that posts the timer cause. The transitions are: load (any state to TM_COUNT on a nonzero host write, or to TM_IDLE on a zero write), expire (TM_COUNT to TM_DONE when a tick meets a count of one), retire (TM_DONE to TM_IDLE) and clear (any state to TM_IDLE under software reset).

Top module: `flop_regcore`

## Requirements
- R1: Register index is address bits [7:4]. An access whose address has any of bits [3:0] set is ignored and reads 0. Indices 0 (data), 3 (mode), 4 (select), 5 (setup), 9 (seek count), 12 (gap length), 13 (first sector), 14 (sector count) and 15 (interrupt enable) read back the last value written.
- R2: A write to index 6 clears every control bit that is 1 in the write data and leaves the others. Reading index 6 returns the control word.
- R3: A write to index 7 sets every control bit that is 1 in the write data and leaves the others.
- R4: Reading index 7 returns a status byte. Bit 1 is the interrupt output, bit 5 is 1 when the error register is nonzero, bit 3 is the drive sense input, and all other bits are 0.
- R5: Cause register (index 8) bits are: bit 0 timer done, bit 1 seek done, bit 2 sector seen, bit 3 transfer done, bit 4 data changed, bit 5 error. Each is set by its event and stays set until read. A read clears the bits it returns, but an event in the same cycle as the read is kept.
- R6: Error register (index 2) records only error-input bits 7, 6, 2 and 0 (mask 0xC5), and each recorded bit is sticky. Any recorded error sets cause bit 5. A read clears the register, except for bits arriving in the same cycle.
- R7: The interrupt output is high exactly when control bit 0 is set and the cause register ANDed with interrupt-enable bits [5:0] is nonzero.
- R8: A nonzero write to index 1 loads the timer, which then decrements once every TICK_DIV clocks. On reaching zero it sets cause bit 0, then stays at zero with no reload.
- R9: A timer write while counting restarts it from the new value. Writing 0 stops it without setting the timer cause.
- R10: Indices 10 and 11 are loaded only from the track and sector sideband ports. Host writes to indices 10, 11, 2 and 8 have no effect.
- R11: While setup bit 7 is 1, the control word, cause register, error register and timer are held at 0. Events and control or timer writes are ignored during that time.
- R12: After reset every register reads 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Host access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Host byte address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| ev_seek_done | input | 1 | Seek finished pulse |
| ev_sec_seen | input | 1 | Sector header seen pulse |
| ev_xfer_done | input | 1 | Transfer finished pulse |
| ev_data_chg | input | 1 | Data line changed pulse |
| err_evt | input | 8 | Error event bits, one cycle per event |
| drv_sense | input | 1 | Sensed drive data line |
| trk_ld | input | 1 | Load strobe for the current-track register |
| trk_val | input | 8 | Current track value |
| sec_ld | input | 1 | Load strobe for the current-sector register |
| sec_val | input | 8 | Current sector value |
| irq | output | 1 | Interrupt request |
| ctl_bits | output | 8 | Control word |
| sel_bits | output | 8 | Select register |
| mode_bits | output | 8 | Mode register |
| setup_bits | output | 8 | Setup register |
| seek_cnt | output | 8 | Seek count register |
| gap_len | output | 8 | Gap length register |
| sec_first | output | 8 | First sector to transfer |
| sec_count | output | 8 | Number of sectors to transfer |

## Verification
The collision that matters most is a clearing read of the cause or error register that falls in the same clock as a new event. The bench raises a seek-done cause and then reads the cause register in the very cycle a sector-seen pulse arrives. The first read must return only the seek bit, and the next read must return only the sector bit. It repeats this on the error register with two different error bits. The scoreboard compares each read against the values predicted from the rule that same-cycle events are kept.

// File: rtl/flop_pkg.sv
package flop_pkg;

    localparam int unsigned DW     = 8;
    localparam int unsigned NCAUSE = 6;
    localparam int unsigned IDX_W  = 4;

    typedef enum logic [IDX_W-1:0] {
        RG_DATA    = 4'd0,
        RG_TIMER   = 4'd1,
        RG_ERROR   = 4'd2,
        RG_MODE    = 4'd3,
        RG_SELECT  = 4'd4,
        RG_SETUP   = 4'd5,
        RG_CTL_CLR = 4'd6,
        RG_CTL_SET = 4'd7,
        RG_CAUSE   = 4'd8,
        RG_SEEKN   = 4'd9,
        RG_TRACK   = 4'd10,
        RG_SECT    = 4'd11,
        RG_GAP     = 4'd12,
        RG_FSECT   = 4'd13,
        RG_NSECT   = 4'd14,
        RG_IEN     = 4'd15
    } reg_idx_e;

    // cause bit positions
    localparam int unsigned CB_TIMER = 0;
    localparam int unsigned CB_SEEK  = 1;
    localparam int unsigned CB_SEC   = 2;
    localparam int unsigned CB_XFER  = 3;
    localparam int unsigned CB_DCHG  = 4;
    localparam int unsigned CB_ERR   = 5;

    localparam int unsigned CTL_IRQ_EN  = 0;
    localparam int unsigned SETUP_SWRST = 7;

    typedef enum logic [1:0] {
        TM_IDLE  = 2'd0,
        TM_COUNT = 2'd1,
        TM_DONE  = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/flop_tick.sv
module flop_tick #(
    parameter int unsigned DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/flop_timer.sv
module flop_timer
    import flop_pkg::*;
#(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic [TW-1:0] cnt,
    output logic          done
);
    tmr_state_e    state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;

    // next-state and next-count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (clr) begin
            state_d = TM_IDLE;
            cnt_d   = '0;
        end else if (load) begin
            cnt_d   = load_val;
            state_d = (load_val != '0) ? TM_COUNT : TM_IDLE;
        end else begin
            unique case (state_q)
                TM_IDLE: begin
                    state_d = TM_IDLE;
                end
                TM_COUNT: begin
                    if (tick) begin
                        cnt_d = cnt_q - 1'b1;
                        if (cnt_q == TW'(1)) state_d = TM_DONE;
                    end
                end
                TM_DONE: begin
                    state_d = TM_IDLE;
                end
                default: begin
                    state_d = TM_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TM_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        cnt  = cnt_q;
        done = 1'b0;
        unique case (state_q)
            TM_IDLE:  done = 1'b0;
            TM_COUNT: done = 1'b0;
            TM_DONE:  done = 1'b1;
            default:  done = 1'b0;
        endcase
    end
endmodule

// File: rtl/flop_causes.sv
module flop_causes
    import flop_pkg::*;
#(
    parameter logic [DW-1:0] ERR_MASK = 8'hC5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rd_cause,
    input  logic              rd_err,
    input  logic [NCAUSE-2:0] evt,
    input  logic [DW-1:0]     err_in,
    output logic [NCAUSE-1:0] cause,
    output logic [DW-1:0]     err
);
    logic [DW-1:0]     err_new;
    logic [NCAUSE-1:0] set_v;

    assign err_new = err_in & ERR_MASK;
    assign set_v   = {(|err_new), evt};

    for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cause[i] <= 1'b0;
            else if (clr)      cause[i] <= 1'b0;
            else if (rd_cause) cause[i] <= set_v[i];
            else               cause[i] <= cause[i] | set_v[i];
        end
    end

    for (genvar j = 0; j < DW; j++) begin : g_err
        if (ERR_MASK[j]) begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      err[j] <= 1'b0;
                else if (clr)    err[j] <= 1'b0;
                else if (rd_err) err[j] <= err_new[j];
                else             err[j] <= err[j] | err_new[j];
            end
        end else begin : g_tied
            assign err[j] = 1'b0;
        end
    end
endmodule

// File: rtl/flop_regcore.sv
module flop_regcore
    import flop_pkg::*;
#(
    parameter int unsigned   AW          = 8,
    parameter int unsigned   STRIDE_LOG2 = 4,
    parameter int unsigned   TICK_DIV    = 200,
    parameter logic [DW-1:0] ERR_MASK    = 8'hC5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ev_seek_done,
    input  logic          ev_sec_seen,
    input  logic          ev_xfer_done,
    input  logic          ev_data_chg,
    input  logic [DW-1:0] err_evt,
    input  logic          drv_sense,
    input  logic          trk_ld,
    input  logic [DW-1:0] trk_val,
    input  logic          sec_ld,
    input  logic [DW-1:0] sec_val,
    output logic          irq,
    output logic [DW-1:0] ctl_bits,
    output logic [DW-1:0] sel_bits,
    output logic [DW-1:0] mode_bits,
    output logic [DW-1:0] setup_bits,
    output logic [DW-1:0] seek_cnt,
    output logic [DW-1:0] gap_len,
    output logic [DW-1:0] sec_first,
    output logic [DW-1:0] sec_count
);
    localparam int unsigned   TOP_SH   = STRIDE_LOG2 + IDX_W;
    localparam logic [AW-1:0] LOW_MASK = AW'((1 << STRIDE_LOG2) - 1);

    reg_idx_e idx;
    logic     acc_ok, wr, rd, swrst;

    logic [DW-1:0] data_q, mode_q, sel_q, setup_q, seekn_q, gap_q;
    logic [DW-1:0] fsect_q, nsect_q, ien_q, trk_q, sect_q;
    logic [DW-1:0] ctl_q, ctl_d;
    logic [DW-1:0] err_q, tmr_cnt, status_v;
    logic [NCAUSE-1:0] cause_q;
    logic          tick, tmr_done;

    // address decode: stride-aligned, in range
    assign acc_ok = bus_en && ((bus_addr & LOW_MASK) == '0) && ((bus_addr >> TOP_SH) == '0);
    assign idx    = reg_idx_e'(bus_addr[STRIDE_LOG2 +: IDX_W]);
    assign wr     = acc_ok && bus_we;
    assign rd     = acc_ok && !bus_we;
    assign swrst  = setup_q[SETUP_SWRST];

    // plain storage and sideband-loaded registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            mode_q  <= '0;
            sel_q   <= '0;
            setup_q <= '0;
            seekn_q <= '0;
            gap_q   <= '0;
            fsect_q <= '0;
            nsect_q <= '0;
            ien_q   <= '0;
            trk_q   <= '0;
            sect_q  <= '0;
        end else begin
            if (wr) begin
                case (idx)
                    RG_DATA:   data_q  <= bus_wdata;
                    RG_MODE:   mode_q  <= bus_wdata;
                    RG_SELECT: sel_q   <= bus_wdata;
                    RG_SETUP:  setup_q <= bus_wdata;
                    RG_SEEKN:  seekn_q <= bus_wdata;
                    RG_GAP:    gap_q   <= bus_wdata;
                    RG_FSECT:  fsect_q <= bus_wdata;
                    RG_NSECT:  nsect_q <= bus_wdata;
                    RG_IEN:    ien_q   <= bus_wdata;
                    default: ;
                endcase
            end
            if (trk_ld) trk_q  <= trk_val;
            if (sec_ld) sect_q <= sec_val;
        end
    end

    // control word: clear-address / set-address
    always_comb begin
        ctl_d = ctl_q;
        if (swrst)                         ctl_d = '0;
        else if (wr && idx == RG_CTL_CLR)  ctl_d = ctl_q & ~bus_wdata;
        else if (wr && idx == RG_CTL_SET)  ctl_d = ctl_q | bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    flop_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    flop_timer #(.TW(DW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (swrst),
        .tick     (tick),
        .load     (wr && idx == RG_TIMER),
        .load_val (bus_wdata),
        .cnt      (tmr_cnt),
        .done     (tmr_done)
    );

    flop_causes #(.ERR_MASK(ERR_MASK)) u_causes (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (swrst),
        .rd_cause (rd && idx == RG_CAUSE),
        .rd_err   (rd && idx == RG_ERROR),
        .evt      ({ev_data_chg, ev_xfer_done, ev_sec_seen, ev_seek_done, tmr_done}),
        .err_in   (err_evt),
        .cause    (cause_q),
        .err      (err_q)
    );

    assign irq = ctl_q[CTL_IRQ_EN] && ((cause_q & ien_q[NCAUSE-1:0]) != '0);

    assign status_v = {2'b00, (err_q != '0), 1'b0, drv_sense, 1'b0, irq, 1'b0};

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            unique case (idx)
                RG_DATA:    bus_rdata = data_q;
                RG_TIMER:   bus_rdata = tmr_cnt;
                RG_ERROR:   bus_rdata = err_q;
                RG_MODE:    bus_rdata = mode_q;
                RG_SELECT:  bus_rdata = sel_q;
                RG_SETUP:   bus_rdata = setup_q;
                RG_CTL_CLR: bus_rdata = ctl_q;
                RG_CTL_SET: bus_rdata = status_v;
                RG_CAUSE:   bus_rdata = {{(DW-NCAUSE){1'b0}}, cause_q};
                RG_SEEKN:   bus_rdata = seekn_q;
                RG_TRACK:   bus_rdata = trk_q;
                RG_SECT:    bus_rdata = sect_q;
                RG_GAP:     bus_rdata = gap_q;
                RG_FSECT:   bus_rdata = fsect_q;
                RG_NSECT:   bus_rdata = nsect_q;
                RG_IEN:     bus_rdata = ien_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign ctl_bits   = ctl_q;
    assign sel_bits   = sel_q;
    assign mode_bits  = mode_q;
    assign setup_bits = setup_q;
    assign seek_cnt   = seekn_q;
    assign gap_len    = gap_q;
    assign sec_first  = fsect_q;
    assign sec_count  = nsect_q;
endmodule

// File: rtl/flop_regcore_chk.sv
module flop_regcore_chk #(
    parameter int unsigned AW          = 8,
    parameter int unsigned STRIDE_LOG2 = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_en,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [7:0]    bus_wdata,
    input logic          irq,
    input logic [7:0]    ctl_bits,
    input logic [7:0]    setup_bits,
    input logic [5:0]    cause,
    input logic [7:0]    ien,
    input logic [7:0]    err,
    input logic [7:0]    tmr_cnt,
    input logic [7:0]    trk_q,
    input logic          trk_ld,
    input logic [7:0]    trk_val
);
    localparam logic [AW-1:0] A_TIMER = AW'(1 << STRIDE_LOG2);
    localparam logic [AW-1:0] A_CLR   = AW'(6 << STRIDE_LOG2);
    localparam logic [AW-1:0] A_SET   = AW'(7 << STRIDE_LOG2);
    localparam logic [AW-1:0] A_CAUSE = AW'(8 << STRIDE_LOG2);

    logic tmr_wr, clr_wr, set_wr, cause_rd, held;
    assign tmr_wr   = bus_en && bus_we && bus_addr == A_TIMER;
    assign clr_wr   = bus_en && bus_we && bus_addr == A_CLR;
    assign set_wr   = bus_en && bus_we && bus_addr == A_SET;
    assign cause_rd = bus_en && !bus_we && bus_addr == A_CAUSE;
    assign held     = setup_bits[7];

    AST_CLR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !held) |=> ((ctl_bits & $past(bus_wdata)) == 8'h00)); // R2

    AST_SET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr && !held) |=> ((ctl_bits & $past(bus_wdata)) == $past(bus_wdata))); // R3

    AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cause_rd && !held) |=> ((cause & $past(cause)) == $past(cause))); // R5

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause & ien[5:0]) == 6'd0) |-> !irq); // R7

    AST_TIMER_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_cnt == 8'd0 && !tmr_wr) |=> (tmr_cnt == 8'd0)); // R8

    AST_TIMER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_cnt != 8'd0 && !tmr_wr && !held) |=>
        (tmr_cnt == $past(tmr_cnt) || tmr_cnt == $past(tmr_cnt) - 8'd1)); // R8

    AST_TRACK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        trk_ld |=> (trk_q == $past(trk_val))); // R10

    AST_SWRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> (ctl_bits == 8'h00 && cause == 6'd0 && err == 8'h00 && tmr_cnt == 8'd0)); // R11
endmodule

bind flop_regcore flop_regcore_chk #(.AW(AW), .STRIDE_LOG2(STRIDE_LOG2)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq        (irq),
    .ctl_bits   (ctl_bits),
    .setup_bits (setup_bits),
    .cause      (cause_q),
    .ien        (ien_q),
    .err        (err_q),
    .tmr_cnt    (tmr_cnt),
    .trk_q      (trk_q),
    .trk_ld     (trk_ld),
    .trk_val    (trk_val)
);

// File: tb/sim_flop_regcore.sv
`timescale 1ns/1ps
module sim_flop_regcore;
    localparam int unsigned DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic       ev_seek = 1'b0, ev_sec = 1'b0, ev_xfer = 1'b0, ev_dchg = 1'b0;
    logic [7:0] err_evt = '0;
    logic       drv_sense = 1'b0;
    logic       trk_ld = 1'b0, sec_ld = 1'b0;
    logic [7:0] trk_val = '0, sec_val = '0;
    logic       irq;
    logic [7:0] ctl_bits, sel_bits, mode_bits, setup_bits, seek_cnt, gap_len, sec_first, sec_count;

    int n_run = 0;
    int n_fail = 0;
    logic mon_rd = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t exp_q[$];

    always #2.5 clk = ~clk;

    flop_regcore #(.TICK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_seek_done(ev_seek), .ev_sec_seen(ev_sec),
        .ev_xfer_done(ev_xfer), .ev_data_chg(ev_dchg),
        .err_evt(err_evt), .drv_sense(drv_sense),
        .trk_ld(trk_ld), .trk_val(trk_val), .sec_ld(sec_ld), .sec_val(sec_val),
        .irq(irq), .ctl_bits(ctl_bits), .sel_bits(sel_bits), .mode_bits(mode_bits),
        .setup_bits(setup_bits), .seek_cnt(seek_cnt), .gap_len(gap_len),
        .sec_first(sec_first), .sec_count(sec_count)
    );

    // monitor: pops one expected item per read cycle
    always @(negedge clk) begin
        #1;
        if (mon_rd) begin
            if (exp_q.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL scoreboard underflow: actual %02h expected none", bus_rdata);
            end else begin
                sb_item_t it;
                it = exp_q.pop_front();
                n_run++;
                if (bus_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] val);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = {idx, 4'h0}; bus_wdata = val;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    // read with optional same-cycle events {dchg,xfer,sec,seek}
    task automatic rd(input logic [7:0] addr, input logic [7:0] exp, input string tag,
                      input logic [3:0] evts = 4'h0, input logic [7:0] errs = 8'h00);
        sb_item_t it;
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = addr;
        {ev_dchg, ev_xfer, ev_sec, ev_seek} = evts; err_evt = errs;
        it.exp = exp; it.tag = tag;
        exp_q.push_back(it);
        mon_rd = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; mon_rd = 1'b0;
        {ev_dchg, ev_xfer, ev_sec, ev_seek} = 4'h0; err_evt = 8'h00;
    endtask

    task automatic pulse(input logic [3:0] evts, input logic [7:0] errs);
        @(negedge clk);
        {ev_dchg, ev_xfer, ev_sec, ev_seek} = evts; err_evt = errs;
        @(negedge clk);
        {ev_dchg, ev_xfer, ev_sec, ev_seek} = 4'h0; err_evt = 8'h00;
    endtask

    task automatic wait_irq(output int k);
        k = 0;
        while (!irq && k < 200) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int k;
        logic [7:0] vals [9] = '{8'hA5, 8'h95, 8'h0B, 8'h28, 8'h22, 8'h1B, 8'h07, 8'h12, 8'h3F};
        logic [3:0] idxs [9] = '{4'd0, 4'd3, 4'd4, 4'd5, 4'd9, 4'd12, 4'd13, 4'd14, 4'd15};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        check({7'd0, irq}, 8'h00, "R12 irq after reset");
        for (int i = 0; i < 16; i++) rd(8'(i << 4), 8'h00, "R12 register after reset");

        // R1 plain storage
        for (int i = 0; i < 9; i++) wr(idxs[i], vals[i]);
        for (int i = 0; i < 9; i++) rd({idxs[i], 4'h0}, vals[i], "R1 readback");
        rd(8'h31, 8'h00, "R1 misaligned read");
        wr(4'd15, 8'h00);

        // R3 set, R2 clear
        wr(4'd7, 8'h8A);
        rd(8'h60, 8'h8A, "R3 set write");
        wr(4'd7, 8'h01);
        rd(8'h60, 8'h8B, "R3 set keeps others");
        wr(4'd6, 8'h82);
        rd(8'h60, 8'h09, "R2 clear write");

        // R5 causes
        pulse(4'b0001, 8'h00);
        rd(8'h80, 8'h02, "R5 seek cause");
        rd(8'h80, 8'h00, "R5 read clears");
        pulse(4'b1100, 8'h00);
        rd(8'h80, 8'h18, "R5 xfer+data causes");
        // R5 same-cycle event kept
        pulse(4'b0001, 8'h00);
        rd(8'h80, 8'h02, "R5 read with same-cycle sector", 4'b0010);
        rd(8'h80, 8'h04, "R5 same-cycle sector kept");

        // R6 error register
        pulse(4'h0, 8'hFF);
        rd(8'h20, 8'hC5, "R6 masked error bits");
        rd(8'h80, 8'h20, "R6 error cause");
        rd(8'h20, 8'h00, "R6 read clears");
        pulse(4'h0, 8'h01);
        rd(8'h20, 8'h01, "R6 read with same-cycle error", 4'h0, 8'h80);
        rd(8'h20, 8'h80, "R6 same-cycle error kept");
        rd(8'h80, 8'h20, "R6 cause drained");

        // R4 status byte (control bit 0 is set)
        wr(4'd15, 8'h20);
        drv_sense = 1'b1;
        pulse(4'h0, 8'h40);
        check({7'd0, irq}, 8'h01, "R4 irq from error");
        rd(8'h70, 8'h2A, "R4 status pending+error+sense");
        rd(8'h20, 8'h40, "R4 error value");
        rd(8'h80, 8'h20, "R4 cause value");
        drv_sense = 1'b0;
        rd(8'h70, 8'h00, "R4 status quiet");

        // R7 interrupt gating
        wr(4'd15, 8'h02);
        pulse(4'b0001, 8'h00);
        check({7'd0, irq}, 8'h01, "R7 irq enabled cause");
        wr(4'd6, 8'h01);
        check({7'd0, irq}, 8'h00, "R7 master enable off");
        wr(4'd7, 8'h01);
        check({7'd0, irq}, 8'h01, "R7 master enable on");
        wr(4'd15, 8'h00);
        check({7'd0, irq}, 8'h00, "R7 mask off");
        rd(8'h80, 8'h02, "R7 cause left pending");

        // R8 timer expiry
        wr(4'd15, 8'h01);
        wr(4'd1, 8'd5);
        wait_irq(k);
        check(8'((k >= 17 && k <= 22) ? 1 : 0), 8'h01, "R8 timer expiry window");
        rd(8'h10, 8'h00, "R8 timer at zero");
        repeat (40) @(negedge clk);
        rd(8'h10, 8'h00, "R8 timer no reload");
        rd(8'h80, 8'h01, "R8 timer cause");

        // R9 restart and stop
        wr(4'd1, 8'd200);
        repeat (20) @(negedge clk);
        wr(4'd1, 8'd3);
        wait_irq(k);
        check(8'((k >= 9 && k <= 14) ? 1 : 0), 8'h01, "R9 restart window");
        rd(8'h80, 8'h01, "R9 restart cause");
        wr(4'd1, 8'd50);
        repeat (10) @(negedge clk);
        wr(4'd1, 8'd0);
        repeat (300) @(negedge clk);
        check({7'd0, irq}, 8'h00, "R9 zero write stops");
        rd(8'h80, 8'h00, "R9 no cause after stop");

        // R10 sideband registers and ignored writes
        @(negedge clk);
        trk_ld = 1'b1; trk_val = 8'h4F; sec_ld = 1'b1; sec_val = 8'h0C;
        @(negedge clk);
        trk_ld = 1'b0; sec_ld = 1'b0;
        wr(4'd10, 8'h11);
        wr(4'd11, 8'h22);
        rd(8'hA0, 8'h4F, "R10 track keeps sideband value");
        rd(8'hB0, 8'h0C, "R10 sector keeps sideband value");
        wr(4'd8, 8'hFF);
        rd(8'h80, 8'h00, "R10 cause write ignored");
        wr(4'd2, 8'hFF);
        rd(8'h20, 8'h00, "R10 error write ignored");

        // R11 software reset
        wr(4'd7, 8'h46);
        pulse(4'b0001, 8'h04);
        wr(4'd5, 8'h80);
        pulse(4'b1111, 8'hFF);
        wr(4'd7, 8'hFF);
        wr(4'd1, 8'd9);
        rd(8'h60, 8'h00, "R11 control held");
        rd(8'h80, 8'h00, "R11 causes held");
        rd(8'h20, 8'h00, "R11 error held");
        rd(8'h10, 8'h00, "R11 timer held");
        check({7'd0, irq}, 8'h00, "R11 irq low");
        wr(4'd5, 8'h00);
        rd(8'h50, 8'h00, "R11 setup released");
        wr(4'd7, 8'h10);
        rd(8'h60, 8'h10, "R11 control usable again");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule